// File: doc/BRIEF.md
# One-Hot Hardwired Instruction Step Sequencer

This block is the control half of a hardwired processor controller. It holds 21 step flip-flops, one for each statement of a fixed control sequence, and exactly one of them is set at a time. On every clock edge the active step passes to its successor. Where the sequence forks, the choice is made directly from a few bits of the instruction register.

The datapath decodes the 21 step lines into its register, bus and ALU controls. That decoding lies outside this block. The sequence covers these paths:

- instruction fetch;
- a four-way format decode;
- a set-high-bits operation and conditional branches;
- a subroutine call;
- arithmetic operations;
- loads;
- stores with their five operand shifts.

Every path ends either at the program-counter increment step or directly back at fetch.

Steps:

| Step | Name |
|------|------|
| 0 | FETCH |
| 1 | DECODE |
| 2 | FMT0 |
| 3 | SETHIGH |
| 4–7 | CALL0–CALL3 |
| 8 | ARG |
| 9 | ALU |
| 10 | MEMARG |
| 11 | MEMADDR |
| 12 | LOAD |
| 13–17 | STSH0–STSH4 |
| 18 | STWR |
| 19 | BRANCH |
| 20 | PCINC |

Transitions:

- FETCH→DECODE.
- DECODE→FMT0, CALL0, ARG or MEMARG.
- FMT0→BRANCH or SETHIGH.
- SETHIGH→PCINC.
- CALL0→CALL1→CALL2→CALL3→FETCH.
- ARG→ALU→PCINC.
- MEMARG→MEMADDR.
- MEMADDR→LOAD or STSH0.
- LOAD→PCINC.
- STSH0→…→STSH4→STWR→PCINC.
- BRANCH→FETCH.
- PCINC→FETCH.

Top module: `hw_step_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next value of `step` is 21'h000001: only bit 0 (FETCH) is set.
- R2: After every clock edge, exactly one bit of `step` is 1.
- R3: FETCH (bit 0) is always followed by DECODE (bit 1).
- R4: From DECODE, `instr[31:30]` selects the next step: 2'b00 goes to FMT0 (bit 2), 2'b01 to CALL0 (bit 4), 2'b10 to ARG (bit 8) and 2'b11 to MEMARG (bit 10).
- R5: From FMT0, the next step is BRANCH (bit 19) when `instr[24]` is 1 and SETHIGH (bit 3) when it is 0. SETHIGH always goes to PCINC (bit 20).
- R6: The call path steps through bits 4, 5, 6 and 7 in order, then returns to FETCH.
- R7: The arithmetic path goes ARG (bit 8) → ALU (bit 9) → PCINC (bit 20).
- R8: MEMARG (bit 10) goes to MEMADDR (bit 11). From MEMADDR, the next step is LOAD (bit 12) when `instr[21]` is 0 and STSH0 (bit 13) when it is 1. LOAD always goes to PCINC.
- R9: The store path steps through bits 13 to 17 in order, then goes to STWR (bit 18), then to PCINC (bit 20).
- R10: BRANCH (bit 19) and PCINC (bit 20) both return to FETCH.
- R11: `instr` matters in only three steps: bits 31:30 in DECODE, bit 24 in FMT0 and bit 21 in MEMADDR. Its value has no effect on the successor of any other step, and no other bit of `instr` has any effect at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction register contents |
| step | output | 21 | One-hot step lines; bit n is step n |

## Verification
The hardest condition to reach from the ports is deep in the store path. Reaching it needs three things in a row: format 2'b11 at DECODE, then bit 21 set two cycles later at MEMADDR, then a reset arriving partway through the five shift steps.

The random stimulus draws a fresh instruction word every cycle. It reaches the store path in roughly one of eight instructions, and it sometimes pulses reset. Directed sequences then guarantee each path once, including a reset issued from inside the store shifts.

Every non-forking step is also exercised with `instr` set to all ones and to all zeros. This shows that the successor of those steps does not depend on the instruction word.

// File: rtl/hws_pkg.sv
package hws_pkg;

    localparam int unsigned NSTEP   = 21;
    localparam int unsigned IR_W    = 32;
    localparam int unsigned SW      = $clog2(NSTEP);
    localparam int unsigned FMT_HI  = 31;
    localparam int unsigned FMT_LO  = 30;
    localparam int unsigned BR_BIT  = 24;
    localparam int unsigned DIR_BIT = 21;
    localparam int unsigned N_SHIFT = 5;

    typedef enum logic [SW-1:0] {
        S_FETCH   = 5'd0,
        S_DECODE  = 5'd1,
        S_FMT0    = 5'd2,
        S_SETHIGH = 5'd3,
        S_CALL0   = 5'd4,
        S_CALL1   = 5'd5,
        S_CALL2   = 5'd6,
        S_CALL3   = 5'd7,
        S_ARG     = 5'd8,
        S_ALU     = 5'd9,
        S_MEMARG  = 5'd10,
        S_MEMADDR = 5'd11,
        S_LOAD    = 5'd12,
        S_STSH0   = 5'd13,
        S_STSH1   = 5'd14,
        S_STSH2   = 5'd15,
        S_STSH3   = 5'd16,
        S_STSH4   = 5'd17,
        S_STWR    = 5'd18,
        S_BRANCH  = 5'd19,
        S_PCINC   = 5'd20
    } step_e;

    typedef enum logic [1:0] {
        F_BRSET = 2'b00,
        F_CALL  = 2'b01,
        F_ARITH = 2'b10,
        F_MEM   = 2'b11
    } fmt_e;

endpackage

// File: rtl/hws_fork_decode.sv
module hws_fork_decode
    import hws_pkg::*;
#(
    parameter int unsigned W = IR_W
) (
    input  logic [W-1:0] instr,
    output logic [3:0]   fmt_sel,
    output logic         take_branch,
    output logic         is_store
);
    fmt_e fmt;

    assign fmt = fmt_e'(instr[FMT_HI:FMT_LO]);

    always_comb begin
        fmt_sel = '0;
        unique case (fmt)
            F_BRSET: fmt_sel[0] = 1'b1;
            F_CALL:  fmt_sel[1] = 1'b1;
            F_ARITH: fmt_sel[2] = 1'b1;
            F_MEM:   fmt_sel[3] = 1'b1;
        endcase
    end

    assign take_branch = instr[BR_BIT];
    assign is_store    = instr[DIR_BIT];

endmodule

// File: rtl/hws_next_logic.sv
module hws_next_logic
    import hws_pkg::*;
#(
    parameter int unsigned N  = NSTEP,
    parameter int unsigned NS = N_SHIFT
) (
    input  logic [N-1:0] cur,
    input  logic [3:0]   fmt_sel,
    input  logic         take_branch,
    input  logic         is_store,
    output logic [N-1:0] nxt
);
    localparam int unsigned SH0 = S_STSH0;

    always_comb begin
        nxt = '0;

        // Steps that end an instruction.
        nxt[S_FETCH]   = cur[S_CALL3] | cur[S_BRANCH] | cur[S_PCINC];
        nxt[S_DECODE]  = cur[S_FETCH];

        // Format fork and the branch / set-high pair.
        nxt[S_FMT0]    = cur[S_DECODE] & fmt_sel[0];
        nxt[S_SETHIGH] = cur[S_FMT0] & ~take_branch;
        nxt[S_BRANCH]  = cur[S_FMT0] & take_branch;

        // Call path.
        nxt[S_CALL0]   = cur[S_DECODE] & fmt_sel[1];
        nxt[S_CALL1]   = cur[S_CALL0];
        nxt[S_CALL2]   = cur[S_CALL1];
        nxt[S_CALL3]   = cur[S_CALL2];

        // Arithmetic path.
        nxt[S_ARG]     = cur[S_DECODE] & fmt_sel[2];
        nxt[S_ALU]     = cur[S_ARG];

        // Memory path: operand, address, then the load / store fork.
        nxt[S_MEMARG]  = cur[S_DECODE] & fmt_sel[3];
        nxt[S_MEMADDR] = cur[S_MEMARG];
        nxt[S_LOAD]    = cur[S_MEMADDR] & ~is_store;
        nxt[S_STSH0]   = cur[S_MEMADDR] & is_store;
        for (int k = 1; k < int'(NS); k++) begin
            nxt[SH0 + k] = cur[SH0 + k - 1];
        end
        nxt[S_STWR]    = cur[SH0 + NS - 1];

        // Common program-counter increment.
        nxt[S_PCINC]   = cur[S_SETHIGH] | cur[S_ALU] | cur[S_LOAD] | cur[S_STWR];
    end

endmodule

// File: rtl/hws_step_reg.sv
module hws_step_reg
    import hws_pkg::*;
#(
    parameter int unsigned N = NSTEP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < int'(N); i++) begin : g_bit
        localparam logic RST_VAL = (i == 0);
        always_ff @(posedge clk) begin
            if (rst) q[i] <= RST_VAL;
            else     q[i] <= d[i];
        end
    end

    AST_RESET_TO_FETCH: assert property (@(posedge clk) rst |=> (q == N'(1))) else $error("reset state"); // R1
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $countones(q) == 1) else $error("not one-hot"); // R2

endmodule

// File: rtl/hw_step_sequencer.sv
module hw_step_sequencer
    import hws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   instr,
    output logic [NSTEP-1:0]  step
);
    logic [3:0]       fmt_sel;
    logic             take_branch;
    logic             is_store;
    logic [NSTEP-1:0] nxt;

    hws_fork_decode #(.W(IR_W)) u_dec (
        .instr       (instr),
        .fmt_sel     (fmt_sel),
        .take_branch (take_branch),
        .is_store    (is_store)
    );

    hws_next_logic #(.N(NSTEP), .NS(N_SHIFT)) u_next (
        .cur         (step),
        .fmt_sel     (fmt_sel),
        .take_branch (take_branch),
        .is_store    (is_store),
        .nxt         (nxt)
    );

    hws_step_reg #(.N(NSTEP)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (step)
    );

    AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst) step[S_FETCH] |=> step[S_DECODE]) else $error("fetch"); // R3
    AST_DEC_BRSET: assert property (@(posedge clk) disable iff (rst) step[S_DECODE] && instr[31:30] == 2'b00 |=> step[S_FMT0]) else $error("dec00"); // R4
    AST_DEC_CALL: assert property (@(posedge clk) disable iff (rst) step[S_DECODE] && instr[31:30] == 2'b01 |=> step[S_CALL0]) else $error("dec01"); // R4
    AST_DEC_ARITH: assert property (@(posedge clk) disable iff (rst) step[S_DECODE] && instr[31:30] == 2'b10 |=> step[S_ARG]) else $error("dec10"); // R4
    AST_DEC_MEM: assert property (@(posedge clk) disable iff (rst) step[S_DECODE] && instr[31:30] == 2'b11 |=> step[S_MEMARG]) else $error("dec11"); // R4
    AST_FMT0_BRANCH: assert property (@(posedge clk) disable iff (rst) step[S_FMT0] && instr[24] |=> step[S_BRANCH]) else $error("branch"); // R5
    AST_FMT0_SETHIGH: assert property (@(posedge clk) disable iff (rst) step[S_FMT0] && !instr[24] |=> step[S_SETHIGH]) else $error("sethigh"); // R5
    AST_CALL_RETURN: assert property (@(posedge clk) disable iff (rst) step[S_CALL3] |=> step[S_FETCH]) else $error("call"); // R6
    AST_ALU_PCINC: assert property (@(posedge clk) disable iff (rst) step[S_ALU] |=> step[S_PCINC]) else $error("alu"); // R7
    AST_MEM_LOAD: assert property (@(posedge clk) disable iff (rst) step[S_MEMADDR] && !instr[21] |=> step[S_LOAD]) else $error("load"); // R8
    AST_MEM_STORE: assert property (@(posedge clk) disable iff (rst) step[S_MEMADDR] && instr[21] |=> step[S_STSH0]) else $error("store"); // R8
    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (rst) step[S_STSH4] |=> step[S_STWR]) else $error("stwr"); // R9
    AST_END_FETCH: assert property (@(posedge clk) disable iff (rst) (step[S_BRANCH] || step[S_PCINC]) |=> step[S_FETCH]) else $error("end"); // R10

endmodule

// File: tb/hw_step_sequencer_test.sv
module hw_step_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [20:0] step;

    int errors = 0;
    int checks = 0;
    int exp_s  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hw_step_sequencer uut (.clk(clk), .rst(rst), .instr(instr), .step(step));

    function automatic int exp_next(int s, logic [31:0] ir);
        case (s)
            0:  return 1;
            1:  case (ir[31:30])
                    2'b00: return 2;
                    2'b01: return 4;
                    2'b10: return 8;
                    default: return 10;
                endcase
            2:  return ir[24] ? 19 : 3;
            3:  return 20;
            4, 5, 6: return s + 1;
            7:  return 0;
            8:  return 9;
            9:  return 20;
            10: return 11;
            11: return ir[21] ? 13 : 12;
            12: return 20;
            13, 14, 15, 16, 17: return s + 1;
            18: return 20;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R3";
            1: return "R4";
            2, 3: return "R5";
            4, 5, 6, 7: return "R6";
            8, 9: return "R7";
            10, 11, 12: return "R8";
            13, 14, 15, 16, 17, 18: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Check at the negedge, then drive the next cycle's inputs.
    task automatic cyc(input logic r, input logic [31:0] ir, input string req);
        @(negedge clk);
        checks++;
        if (step !== (21'd1 << exp_s)) begin
            errors++;
            $display("FAIL %s: step=%h expected=%h", req, step, 21'd1 << exp_s);
        end
        checks++;
        if ($countones(step) != 1) begin
            errors++;
            $display("FAIL R2: step=%h expected one bit set", step);
        end
        rst   = r;
        instr = ir;
        exp_s = r ? 0 : exp_next(exp_s, ir);
    endtask

    // Prefix from FETCH with the chosen fork bits; r11_ other bits flipped by fill.
    task automatic run_path(input logic [1:0] f, input logic br, input logic st,
                            input logic [31:0] fill, input int n);
        logic [31:0] ir;
        for (int k = 0; k < n; k++) begin
            ir = fill;
            ir[31:30] = f;
            ir[24] = br;
            ir[21] = st;
            cyc(1'b0, ir, req_of(exp_s));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        cyc(1'b1, '0, "R1");
        cyc(1'b0, '0, "R1");
        // Directed: every path, fill all-ones then all-zeros (R11).
        for (int p = 0; p < 2; p++) begin
            logic [31:0] fl;
            fl = p ? 32'h0 : 32'hFFFF_FFFF;
            run_path(2'b00, 1'b1, 1'b0, fl, 4);
            run_path(2'b00, 1'b0, 1'b1, fl, 5);
            run_path(2'b01, 1'b0, 1'b0, fl, 6);
            run_path(2'b10, 1'b1, 1'b1, fl, 5);
            run_path(2'b11, 1'b0, 1'b0, fl, 6);
            run_path(2'b11, 1'b1, 1'b1, fl, 11);
        end
        // Reset from inside the store shifts (R1).
        run_path(2'b11, 1'b1, 1'b1, 32'h0, 6);
        cyc(1'b1, 32'hFFFF_FFFF, "R1");
        cyc(1'b0, 32'h0, "R1");
        // Random stimulus (R11 for don't-care bits).
        for (int k = 0; k < 4000; k++) begin
            logic r;
            r = ($urandom % 97) == 0;
            cyc(r, $urandom, r ? "R1" : req_of(exp_s));
        end
        cyc(1'b0, '0, "R10");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule